// File: doc/BRIEF.md
# Per-Core Cascaded Tick Timer

This block is the private event timer of one processor core. A prescale stage divides the input clock into ticks, and a second down-counter counts those ticks and raises an interrupt when it runs out. Each stage has its own start bit, so software can keep the tick stage running while it pauses the interrupt stage. Software can also freeze both stages at once.

Three registers are buffered: the tick reload, the interrupt count and the control word. A write to any of them takes effect a fixed number of clock cycles after the bus write. When the write has been applied, the block sets an acknowledge bit that software clears again. In interval mode the interrupt stage reloads itself and fires periodically. Without interval mode it fires once and then rests at zero.

Top module: `core_tick_timer`

Register addresses (`wr_addr` and `rd_addr`):

| Address | Register | Write behaviour |
|---|---|---|
| 0 | tick reload | buffered |
| 1 | interrupt count buffer | buffered |
| 2 | control | buffered |
| 3 | interrupt enable | immediate |
| 4 | interrupt status | write-one-to-clear |
| 5 | write acknowledge | write-one-to-clear |
| 6 | live interrupt counter | read-only, writes ignored |
| 7 | live tick counter | read-only, writes ignored |

Bit assignments:

- Control: bit0 = timer run, bit1 = interrupt-stage run, bit2 = interval mode.
- Write acknowledge: bit0 = tick reload applied, bit1 = interrupt count applied, bit3 = control applied.

## Requirements
- R1: With tick reload value B and the timer running, the tick stage produces one tick every B+1 clock cycles. A write of the tick reload also loads the live tick counter.
- R2: A count of N in the interrupt stage expires on the Nth tick after the start. If the control write that starts the timer is applied at edge S and the live tick counter held B, the interrupt status is set at edge S+N*(B+1).
- R3: In interval mode (control bit2 = 1) the interrupt stage reloads from its buffer at each expiry. It then interrupts every N*(B+1) cycles until the run bits are cleared.
- R4: Without interval mode the interrupt stage stops at zero after one expiry and raises exactly one interrupt.
- R5: A write to address 1 with bit31 set loads bits 30:0 into both the count buffer and the live interrupt counter. A write with bit31 clear leaves both unchanged.
- R6: A requested interrupt count below 15 is raised to 15.
- R7: Clearing control bit0 freezes both counters. Clearing only control bit1 freezes the interrupt counter while ticks continue.
- R8: A write to address 0, 1 or 2 sampled at clock edge n is applied at edge n+WR_LAT. At that same edge it sets acknowledge bit 0, 1 or 3 respectively.
- R9: Writing ones to address 5 clears exactly those acknowledge bits, at the edge that samples the write.
- R10: Interrupt status bit0 is set on expiry and held until a one is written to address 4. An expiry in the same cycle as the clear wins.
- R11: The `irq` output equals status bit0 AND enable bit0 (address 3).
- R12: After reset every register and both counters read zero and `irq` is low.
- R13: The read address map follows the table above, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with WR_LAT = 3, so the apply edge stands apart from the write edge. It checks the acknowledge bit one cycle before the apply edge and again at that edge. It uses a tick reload of 2 and counts of 15 and 20, which bring periodic expiries, the one-shot stop, the minimum-count clamp and both freeze modes within a few hundred cycles. Every interrupt edge is compared with the exact cycle predicted from the start edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] RA_TBUF  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_IBUF  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_ISTAT = 3'd4;
  localparam logic [ADDR_W-1:0] RA_WSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] RA_ICUR  = 3'd6;
  localparam logic [ADDR_W-1:0] RA_TCUR  = 3'd7;

  // control bits
  localparam int CTL_TRUN = 0;
  localparam int CTL_IRUN = 1;
  localparam int CTL_IVAL = 2;
  localparam int CTL_W    = 3;

  // acknowledge bits
  localparam int WS_TBUF = 0;
  localparam int WS_IBUF = 1;
  localparam int WS_CTRL = 3;
  localparam int WS_W    = 4;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/tt_wr_delay.sv
module tt_wr_delay
  import tick_timer_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_req_t req_in,
  output wr_req_t req_out
);
  wr_req_t stage_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    wr_req_t stage_d;
    if (i == 0) begin : g_first
      always_comb stage_d = req_in;
    end else begin : g_next
      always_comb stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_d;
    end
  end

  assign req_out = stage_q[LAT-1];
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         tick
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign tick   = run && (cnt == '0) && !load;
  assign cnt_en = load || run;

  always_comb begin
    cnt_d = cnt;
    if (load)                cnt_d = load_val;
    else if (cnt == '0)      cnt_d = reload_val;
    else                     cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/tt_int_counter.sv
module tt_int_counter #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         interval,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic [W-1:0] cnt_d;
  logic         step;
  logic         cnt_en;

  assign step   = tick && run && (cnt != '0) && !load;
  assign expire = step && (cnt == W'(1));
  assign cnt_en = load || step;

  always_comb begin
    cnt_d = cnt;
    if (load)        cnt_d = load_val;
    else if (expire) cnt_d = interval ? reload_val : '0;
    else             cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int TCNT_W   = 8,
  parameter int ICNT_W   = 31,
  parameter int ICNT_MIN = 15,
  parameter int WR_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int UPD_BIT = DATA_W - 1;
  localparam logic [ICNT_W-1:0] MIN_V = ICNT_W'(ICNT_MIN);

  // register state
  logic [TCNT_W-1:0] tbuf_q, tbuf_d;
  logic [ICNT_W-1:0] ibuf_q, ibuf_d;
  logic [CTL_W-1:0]  ctrl_q, ctrl_d;
  logic              ien_q, ien_d;
  logic              istat_q, istat_d;
  logic [WS_W-1:0]   wstat_q, wstat_d;

  wr_req_t req_in, req_app;
  logic tbuf_ld, ibuf_wr, ibuf_ld, ctrl_ld;
  logic ien_wr, istat_clr;
  logic [WS_W-1:0] wstat_clr, wstat_set;
  logic [ICNT_W-1:0] ibuf_new;
  logic [TCNT_W-1:0] tcnt;
  logic [ICNT_W-1:0] icnt;
  logic tick, expire;

  assign req_in = '{vld: wr_en, addr: wr_addr, data: wr_data};

  tt_wr_delay #(.LAT(WR_LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .req_out(req_app)
  );

  // decode of applied (delayed) writes
  assign tbuf_ld  = req_app.vld && (req_app.addr == RA_TBUF);
  assign ibuf_wr  = req_app.vld && (req_app.addr == RA_IBUF);
  assign ibuf_ld  = ibuf_wr && req_app.data[UPD_BIT];
  assign ctrl_ld  = req_app.vld && (req_app.addr == RA_CTRL);
  assign ibuf_new = (req_app.data[ICNT_W-1:0] < MIN_V) ? MIN_V
                                                       : req_app.data[ICNT_W-1:0];

  // decode of immediate writes
  assign ien_wr    = wr_en && (wr_addr == RA_IEN);
  assign istat_clr = wr_en && (wr_addr == RA_ISTAT) && wr_data[0];
  assign wstat_clr = (wr_en && (wr_addr == RA_WSTAT)) ? wr_data[WS_W-1:0] : '0;

  always_comb begin
    wstat_set          = '0;
    wstat_set[WS_TBUF] = tbuf_ld;
    wstat_set[WS_IBUF] = ibuf_wr;
    wstat_set[WS_CTRL] = ctrl_ld;
  end

  tt_prescaler #(.W(TCNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q[CTL_TRUN]),
    .load(tbuf_ld), .load_val(req_app.data[TCNT_W-1:0]),
    .reload_val(tbuf_q),
    .cnt(tcnt), .tick(tick)
  );

  tt_int_counter #(.W(ICNT_W)) u_icnt (
    .clk(clk), .rst_n(rst_n),
    .tick(tick),
    .run(ctrl_q[CTL_TRUN] && ctrl_q[CTL_IRUN]),
    .interval(ctrl_q[CTL_IVAL]),
    .load(ibuf_ld), .load_val(ibuf_new),
    .reload_val(ibuf_q),
    .cnt(icnt), .expire(expire)
  );

  // next state
  always_comb begin
    tbuf_d  = tbuf_ld ? req_app.data[TCNT_W-1:0] : tbuf_q;
    ibuf_d  = ibuf_ld ? ibuf_new : ibuf_q;
    ctrl_d  = ctrl_ld ? req_app.data[CTL_W-1:0] : ctrl_q;
    ien_d   = ien_wr ? wr_data[0] : ien_q;
    istat_d = expire | (istat_q & ~istat_clr);
    wstat_d = wstat_set | (wstat_q & ~wstat_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf_q  <= '0;
      ibuf_q  <= '0;
      ctrl_q  <= '0;
      ien_q   <= 1'b0;
      istat_q <= 1'b0;
      wstat_q <= '0;
    end else begin
      tbuf_q  <= tbuf_d;
      ibuf_q  <= ibuf_d;
      ctrl_q  <= ctrl_d;
      ien_q   <= ien_d;
      istat_q <= istat_d;
      wstat_q <= wstat_d;
    end
  end

  assign irq = istat_q & ien_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_TBUF:  rd_data = DATA_W'(tbuf_q);
      RA_IBUF:  rd_data = DATA_W'(ibuf_q);
      RA_CTRL:  rd_data = DATA_W'(ctrl_q);
      RA_IEN:   rd_data = DATA_W'(ien_q);
      RA_ISTAT: rd_data = DATA_W'(istat_q);
      RA_WSTAT: rd_data = DATA_W'(wstat_q);
      RA_ICUR:  rd_data = DATA_W'(icnt);
      RA_TCUR:  rd_data = DATA_W'(tcnt);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tick_timer_pkg::*;
#(
  parameter int TCNT_W   = 8,
  parameter int ICNT_W   = 31,
  parameter int ICNT_MIN = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              ien_q,
  input logic              istat_q,
  input logic              istat_clr,
  input logic              expire,
  input logic              ctrl_ld,
  input logic              tbuf_ld,
  input logic              ibuf_ld,
  input logic [CTL_W-1:0]  ctrl_q,
  input logic [WS_W-1:0]   wstat_q,
  input logic [TCNT_W-1:0] tcnt,
  input logic [ICNT_W-1:0] icnt,
  input logic [ICNT_W-1:0] ibuf_q
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q && istat_q)); // R11

  AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> istat_q); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_q && !istat_clr) |=> istat_q); // R10

  AST_CTRL_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wstat_q[WS_CTRL]) |-> $past(ctrl_ld)); // R8

  AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_TRUN] && !tbuf_ld) |=> $stable(tcnt)); // R7

  AST_ICNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_IRUN] && !ibuf_ld) |=> $stable(icnt)); // R7

  AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt == '0 && !ibuf_ld) |=> (icnt == '0)); // R4

  AST_BUF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ibuf_q == '0) || (ibuf_q >= ICNT_W'(ICNT_MIN))); // R6
endmodule

bind core_tick_timer tt_checker #(
  .TCNT_W(TCNT_W), .ICNT_W(ICNT_W), .ICNT_MIN(ICNT_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ien_q(ien_q), .istat_q(istat_q),
  .istat_clr(istat_clr), .expire(expire), .ctrl_ld(ctrl_ld),
  .tbuf_ld(tbuf_ld), .ibuf_ld(ibuf_ld), .ctrl_q(ctrl_q), .wstat_q(wstat_q),
  .tcnt(tcnt), .icnt(icnt), .ibuf_q(ibuf_q)
);

// File: tb/sim_core_tick_timer.sv
`timescale 1ns/1ps
module sim_core_tick_timer;
  localparam int LAT = 3;
  localparam int B   = 2;
  localparam logic [31:0] UPD = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];
  logic irq_q = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_tick_timer #(.TCNT_W(8), .ICNT_W(31), .ICNT_MIN(15), .WR_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // returns at the negedge after the sampling edge; k = that edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int k);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    k = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compares interrupt edges against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !irq_q) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 R4 unexpected irq", 32'(cyc), 32'hFFFF_FFFF);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R1 R2 R3 irq edge", 32'(cyc), 32'(e));
        end
      end
      irq_q <= irq;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired, run hung");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int k, s;
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R12 reset register", v, 0);
    end
    chk(irq == 1'b0, "R12 reset irq", 32'(irq), 0);

    // R8 apply latency and ack, R1 tick reload load
    wr(3'd0, 32'(B), k);
    wait_until(k + LAT - 1);
    rd(3'd5, v);
    chk(v[0] == 1'b0, "R8 ack too early", v, 0);
    wait_until(k + LAT);
    rd(3'd5, v);
    chk(v == 32'h1, "R8 ack bit0 at apply edge", v, 32'h1);
    rd(3'd7, v);
    chk(v == B, "R1 tick counter loaded", v, B);
    rd(3'd0, v);
    chk(v == B, "R13 tick reload readback", v, B);

    // R9 W1C acknowledge
    wr(3'd5, 32'h1, k);
    rd(3'd5, v);
    chk(v == 0, "R9 ack cleared", v, 0);

    // R5 write without update flag ignored
    wr(3'd1, 32'h40, k);
    wait_until(k + LAT);
    rd(3'd1, v);
    chk(v == 0, "R5 buffer unchanged without flag", v, 0);
    rd(3'd6, v);
    chk(v == 0, "R5 counter unchanged without flag", v, 0);
    rd(3'd5, v);
    chk(v == 32'h2, "R8 ack bit1 only", v, 32'h2);
    wr(3'd5, 32'h2, k);

    // R6 clamp
    wr(3'd1, UPD | 32'd5, k);
    wait_until(k + LAT);
    rd(3'd1, v);
    chk(v == 15, "R6 buffer clamped", v, 15);
    rd(3'd6, v);
    chk(v == 15, "R5 R6 counter loaded", v, 15);

    // R3 interval mode, N=20
    wr(3'd1, UPD | 32'd20, k);
    wr(3'd3, 32'h1, k);
    wr(3'd2, 32'h7, k);
    s = k + LAT;
    exp_q.push_back(s + 20 * (B + 1));
    exp_q.push_back(s + 40 * (B + 1));
    wait_until(s);
    rd(3'd2, v);
    chk(v == 7, "R13 control readback", v, 7);
    rd(3'd5, v);
    chk(v == 32'hA, "R8 ack bits 1 and 3", v, 32'hA);
    wait_until(s + 20 * (B + 1) + 1);
    wr(3'd4, 32'h1, k);
    rd(3'd4, v);
    chk(v == 0, "R10 status cleared", v, 0);
    wait_until(s + 40 * (B + 1) + 1);
    rd(3'd4, v);
    chk(v == 1, "R10 status set again", v, 1);
    wr(3'd4, 32'h1, k);

    // R7 stop: both counters freeze
    wr(3'd2, 32'h0, k);
    wait_until(k + LAT);
    rd(3'd6, v); rd(3'd7, v2);
    repeat (10) @(negedge clk);
    rd(3'd6, k); chk(32'(k) == v, "R7 icnt frozen on stop", 32'(k), v);
    rd(3'd7, k); chk(32'(k) == v2, "R7 tick frozen on stop", 32'(k), v2);

    // R7 interrupt stage paused, ticks continue
    wr(3'd2, 32'h5, k);
    wait_until(k + LAT + 1);
    rd(3'd6, v);
    rd(3'd7, v2);
    @(negedge clk);
    rd(3'd7, k);
    chk(32'(k) != v2, "R7 tick runs with int stage off", 32'(k), v2);
    repeat (10) @(negedge clk);
    rd(3'd6, k);
    chk(32'(k) == v, "R7 icnt frozen with int stage off", 32'(k), v);

    // R4 one-shot
    wr(3'd2, 32'h0, k);
    wr(3'd0, 32'(B), k);
    wr(3'd1, UPD | 32'd15, k);
    wr(3'd2, 32'h3, k);
    s = k + LAT;
    exp_q.push_back(s + 15 * (B + 1));
    wait_until(s + 15 * (B + 1) + 1);
    rd(3'd6, v);
    chk(v == 0, "R4 counter rests at zero", v, 0);
    wr(3'd4, 32'h1, k);
    repeat (100) @(negedge clk);
    chk(irq == 1'b0, "R4 single interrupt only", 32'(irq), 0);
    rd(3'd4, v);
    chk(v == 0, "R4 no second expiry", v, 0);

    // R11 enable gates irq
    wr(3'd3, 32'h0, k);
    wr(3'd1, UPD | 32'd15, k);
    repeat (80) @(negedge clk);
    rd(3'd4, v);
    chk(v == 1, "R11 status set while disabled", v, 1);
    chk(irq == 1'b0, "R11 irq masked", 32'(irq), 0);
    wr(3'd4, 32'h1, k);
    rd(3'd4, v);
    chk(v == 0, "R10 W1C status", v, 0);

    chk(exp_q.size() == 0, "R2 R3 missing interrupts", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule